// File: doc/BRIEF.md
# Software Watchdog Down-Counter

This block watches for software that has stopped running normally. Software controls it through one 8-bit register. The top bit is an activation latch. The low seven bits are a down-counter that software reloads to show that it is still alive. Once the latch is set, the counter loses one every `TICK_CYCLES` clock cycles, where that count comes from a fixed prescaler. If software stops reloading it, the counter eventually drops below its timeout boundary. The block then raises a one-cycle reset request to the chip's reset manager. The watchdog is one of three reset sources for that manager; the other two are the external pin and the supply monitor.

Activation only goes one way. Software can set the latch, but no register write can clear it; only a system reset can. The timeout point is the fall of counter bit 6. A loaded value of C0h therefore gives the shortest timeout, one tick, and FFh gives the longest, 64 ticks. A freeze input stops both the prescaler and the counter, for use while the chip is halted.

Top module: `wdog_timer`

## Requirements
- R1: After reset `rdData` reads 7Fh (latch clear, counter all ones) and `rstReq` is low. While the latch is clear, the counter never changes except by a write, and `rstReq` stays low.
- R2: A write with `wrData[7]`=1 sets the activation latch (`rdData[7]`). A later write with `wrData[7]`=0 leaves it set. Only `rstN` clears it.
- R3: While the latch is set and `freeze` is low, the counter decreases by one every `TICK_CYCLES` cycles, counted from the last write. The step from 00h wraps to 7Fh.
- R4: `rstReq` is high for exactly one cycle: the cycle after a tick that starts from a count in 01h..40h, so that bit 6 of the new count is 0. A tick from any other count leaves `rstReq` low.
- R5: A write (`wrEn`=1) loads `wrData[6:0]` into the counter in either latch state and restarts the prescaler from zero. A write takes priority over a tick in the same cycle, and `rstReq` is low in the cycle after a write.
- R6: While `freeze` is high, the prescaler and the counter both hold, and no reset request is made. Counting resumes from the held prescaler position when `freeze` drops.
- R7: Writing a value with bit 7 set and bit 6 clear (for example BFh) makes the first tick, `TICK_CYCLES` cycles after the write, raise `rstReq`.
- R8: `rdData` always shows the latch in bit 7 and the current counter in bits 6..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrData | input | 8 | Write data: bit 7 activation, bits 6..0 counter load |
| freeze | input | 1 | Holds prescaler and counter while high |
| rdData | output | 8 | Register read value: latch and counter |
| rstReq | output | 1 | One-cycle reset request to the reset manager |

## Verification
The assertions check on every cycle that the latch is sticky, that `rstReq` never stays high for two cycles and never appears while the watchdog is inactive, that the counter only holds, steps down by one or takes a written value, and that a frozen cycle changes nothing. Only the bench scenarios can show the timing. They confirm that ticks arrive exactly every `TICK_CYCLES` cycles after a write and resume correctly after a freeze. They also confirm which of the 128 loaded counts produce a request on which tick, including the 40h/41h boundary and the wrap from 00h.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Strobes passed from the control half to the counter datapath.
  typedef struct packed {
    logic load;   // register write: reload counter
    logic tick;   // prescaler expired: decrement counter
  } wdStrobes_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int TICK_CYCLES = 12288
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrActivate,
  input  logic       freeze,
  output logic       active,
  output wdStrobes_t strobes
);
  localparam int PRE_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] preCnt;
  logic             running;
  logic             preLast;

  assign running = active && !freeze && !wrEn;
  assign preLast = (preCnt == PRE_LAST);

  // Activation latch: set by a write, cleared only by reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   active <= 1'b0;
    else if (wrEn && wrActivate) active <= 1'b1;
  end

  // Prescaler: restarts on write, holds when frozen or inactive.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (wrEn)    preCnt <= '0;
    else if (running) preCnt <= preLast ? '0 : preCnt + 1'b1;
  end

  always_comb begin
    strobes.load = wrEn;
    strobes.tick = running && preLast;
  end
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobes_t       strobes,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             rstReq
);
  localparam int FIRE_BIT = CNT_W - 1;

  logic [CNT_W-1:0] countDec;
  logic             crossing;

  assign countDec = count - 1'b1;
  // Timeout when a nonzero count steps to a value with its top bit clear.
  assign crossing = (count != '0) && !countDec[FIRE_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '1;
    else if (strobes.load)  count <= loadVal;
    else if (strobes.tick)  count <= countDec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstReq <= 1'b0;
    else       rstReq <= strobes.tick && !strobes.load && crossing;
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int TICK_CYCLES = 12288,
  parameter int CNT_W       = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CNT_W:0]   wrData,
  input  logic             freeze,
  output logic [CNT_W:0]   rdData,
  output logic             rstReq
);
  wdStrobes_t       strobes;
  logic             active;
  logic [CNT_W-1:0] count;

  wdog_ctrl #(.TICK_CYCLES(TICK_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrActivate (wrData[CNT_W]),
    .freeze     (freeze),
    .active     (active),
    .strobes    (strobes)
  );

  wdog_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .loadVal (wrData[CNT_W-1:0]),
    .count   (count),
    .rstReq  (rstReq)
  );

  assign rdData = {active, count};
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W = 7
) (
  input logic           clk,
  input logic           rstN,
  input logic           wrEn,
  input logic [CNT_W:0] wrData,
  input logic           freeze,
  input logic [CNT_W:0] rdData,
  input logic           rstReq
);
  p_inactive_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[CNT_W] |-> !rstReq);

  p_active_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[CNT_W] |=> rdData[CNT_W]);

  p_activate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[CNT_W]) |=> rdData[CNT_W]);

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (rdData[CNT_W-1:0] == $past(rdData[CNT_W-1:0])) ||
              (rdData[CNT_W-1:0] == CNT_W'($past(rdData[CNT_W-1:0]) - 1'b1)));

  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  p_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData[CNT_W-1:0] == $past(wrData[CNT_W-1:0])) && !rstReq);

  p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (freeze && !wrEn) |=> $stable(rdData) && !rstReq);
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrData (wrData),
  .freeze (freeze),
  .rdData (rdData),
  .rstReq (rstReq)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  localparam int PERIOD = 10;
  localparam int TICKS  = 4;
  localparam int LIMIT  = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       freeze = 1'b0;
  logic [7:0] rdData;
  logic       rstReq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Bench model state, derived from the requirements.
  logic [6:0] mCnt;
  logic       mAct;
  int         mPre;
  logic       mReq;

  wdog_timer #(.TICK_CYCLES(TICKS), .CNT_W(7)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .freeze(freeze), .rdData(rdData), .rstReq(rstReq)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mCnt = 7'h7F; mAct = 1'b0; mPre = 0; mReq = 1'b0;
  endtask

  // Advance one clock with current inputs; update model; sample after the edge.
  task automatic step(input string tag);
    logic [6:0] nxt;
    if (wrEn) begin
      mCnt = wrData[6:0]; mAct = mAct | wrData[7]; mPre = 0; mReq = 1'b0;
    end else if (mAct && !freeze) begin
      if (mPre == TICKS - 1) begin
        nxt  = mCnt - 7'd1;
        mReq = (mCnt != 7'd0) && !nxt[6];
        mCnt = nxt; mPre = 0;
      end else begin
        mPre++; mReq = 1'b0;
      end
    end else begin
      mReq = 1'b0;
    end
    @(posedge clk);
    #2;
    chk(rdData == {mAct, mCnt}, tag, rdData, {mAct, mCnt});
    chk(rstReq == mReq, tag, rstReq, mReq);
  endtask

  task automatic writeReg(input logic [7:0] v, input string tag);
    wrEn = 1'b1; wrData = v;
    step(tag);
    wrEn = 1'b0;
  endtask

  initial begin
    modelReset();
    #(PERIOD*3);
    @(posedge clk); #2;
    rstN = 1'b1;
    // R1: reset state
    chk(rdData == 8'h7F, "R1", rdData, 8'h7F);
    chk(rstReq == 1'b0, "R1", rstReq, 0);
    // R1: inactive counter holds
    for (int i = 0; i < 40; i++) step("R1");
    // R5/R2: inactive write loads without activating
    writeReg(8'h55, "R5");
    for (int i = 0; i < 12; i++) step("R1");
    // R2: activate, then a bit-7-clear write keeps latch set
    writeReg(8'hC5, "R2");
    for (int i = 0; i < 6; i++) step("R3");
    writeReg(8'h48, "R2");
    chk(rdData[7] == 1'b1, "R2", rdData[7], 1);
    // R5: write mid-prescale restarts prescaler
    for (int i = 0; i < 3; i++) step("R5");
    writeReg(8'hC8, "R5");
    for (int i = 0; i < 3; i++) step("R5");
    chk(rdData[6:0] == 7'h48, "R5", rdData[6:0], 7'h48);
    step("R3");
    chk(rdData[6:0] == 7'h47, "R3", rdData[6:0], 7'h47);
    // R6: freeze holds everything
    writeReg(8'hC1, "R6");
    freeze = 1'b1;
    for (int i = 0; i < 20; i++) step("R6");
    chk(rdData == 8'hC1, "R6", rdData, 8'hC1);
    freeze = 1'b0;
    for (int i = 0; i < TICKS - 1; i++) step("R6");
    step("R4");
    chk(rstReq == 1'b0, "R4", rstReq, 0);
    for (int i = 0; i < TICKS; i++) step("R4");
    chk(rstReq == 1'b1, "R4", rstReq, 1);
    step("R4");
    // R7: bit 6 clear load requests on first tick
    writeReg(8'hBF, "R7");
    for (int i = 0; i < TICKS; i++) step("R7");
    chk(rstReq == 1'b1, "R7", rstReq, 1);
    // R3/R4/R8: sweep every loaded count for five ticks
    for (int v = 0; v < 128; v++) begin
      writeReg(8'h80 | 8'(v), "R8");
      for (int i = 0; i < 5*TICKS; i++) step("R4");
    end
    // R2/R1: reset clears the latch
    rstN = 1'b0;
    #(PERIOD);
    modelReset();
    chk(rdData == 8'h7F, "R2", rdData, 8'h7F);
    @(posedge clk); #2;
    rstN = 1'b1;
    for (int i = 0; i < 12; i++) step("R1");
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule